// File: doc/BRIEF.md
# Dual-Port SDRAM Front End with Request/Grant Arbitration

This block lets two agents share one single-port SDR SDRAM as if it were a dual-port memory. One agent only writes and the other only reads. Each agent raises a request with an address and then waits for a grant. The block never buffers a request. When both agents ask at once, it picks one and withholds the other's grant, so the losing agent simply keeps asking.

A command sequencer opens the bank and row that the selected agent addresses. It then issues one column command per granted cycle for as long as that agent keeps hitting the same bank and row. After that it closes the row with an all-bank precharge and waits out the precharge time. Only one bank is ever open. Read data returns on a registered output, together with a valid flag that rises exactly when the data belongs to an earlier read grant.

Every output toward the SDRAM comes straight from a flip-flop. Power-up, mode setup and refresh are handled elsewhere, and the memory is assumed ready before the block starts.

Top module: `sdram_dualport_ctrl`

## Requirements
- R1: During and right after reset, the command pins show NOP, DQM is all ones, the data output enable is low, and both grants and the read valid flag are low. Commands are encoded on the three pins {ras_n, cas_n, we_n} as follows: NOP 111, ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010.
- R2: An agent address splits into three fields. The top BANK_W bits are the bank, the next ROW_W bits are the row and the low COL_W bits are the column. ACTIVATE drives the bank and the row. READ and WRITE drive the open bank and put the column, zero-extended, on the address pins, with pin 10 low.
- R3: DQM is all zeros exactly on the cycles that carry a READ or WRITE command, and all ones on every other cycle.
- R4: On a WRITE command cycle, the data output carries the write data presented with that grant and the output enable is high. The output enable is low on all other cycles.
- R5: Exactly TRCD_NOPS NOP cycles separate an ACTIVATE from the first column command. A request arriving at an idle block is granted TRCD_NOPS+1 cycles after it is raised.
- R6: Each grant produces exactly one column command in the following cycle. While the owning agent keeps requesting the same bank and row, it is granted on consecutive cycles and no further ACTIVATE is issued.
- R7: When the owner stops requesting, or moves to a different bank or row, the next command is PRECHARGE with address pin 10 high. Exactly TRP_NOPS NOP cycles follow before a waiting request causes the next ACTIVATE. A moved request is therefore granted again TRP_NOPS+TRCD_NOPS+3 cycles after its previous grant.
- R8: The read valid flag is high exactly CAS_LAT+2 cycles after each read grant and at no other time. Its data is the value the memory drove CAS_LAT cycles after the READ command appeared on the pins.
- R9: The two grants are never high together. While a row is open, only the agent that opened it can be granted, and not at all after it has moved to another bank or row.
- R10: When both agents request at an idle block, the agent that did not own the previous row wins, and the writer wins first after reset. The losing agent is granted TRP_NOPS+TRCD_NOPS+3 cycles after the winner's last grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write agent request |
| wr_addr | input | ADDR_W | Write address {bank, row, column} |
| wr_data | input | DATA_W | Write data |
| wr_grant | output | 1 | Write accepted this cycle |
| rd_req | input | 1 | Read agent request |
| rd_addr | input | ADDR_W | Read address {bank, row, column} |
| rd_grant | output | 1 | Read accepted this cycle |
| rd_data | output | DATA_W | Returned read data |
| rd_valid | output | 1 | rd_data holds data for a read grant |
| sd_cmd | output | 3 | {ras_n, cas_n, we_n} command |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | DATA_W/8 | Byte masks |
| sd_dq_out | output | DATA_W | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from memory |

## Verification
The bench builds the block with CAS_LAT=2, TRCD_NOPS=1 and TRP_NOPS=2, and with the default 16-bit data and the 1/11/8 address split. Because both wait counts are non-zero, the NOP gaps after ACTIVATE and after PRECHARGE can be seen and counted. The four-cycle read pipeline leaves room to check a valid flag that arrives one cycle too early or too late. The extreme addresses, all zeros and all ones, reach both banks, the end rows and the end columns.

// File: rtl/sdram_dualport_ctrl.sv
`timescale 1ns/1ps
module sdram_dualport_ctrl #(
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int CAS_LAT   = 2,
  parameter int TRCD_NOPS = 1,
  parameter int TRP_NOPS  = 2,
  parameter int ADDR_W    = BANK_W + ROW_W + COL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  wr_grant,
  input  logic                  rd_req,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic                  rd_grant,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [2:0]            sd_cmd,
  output logic [BANK_W-1:0]     sd_ba,
  output logic [ROW_W-1:0]      sd_a,
  output logic [DATA_W/8-1:0]   sd_dqm,
  output logic [DATA_W-1:0]     sd_dq_out,
  output logic                  sd_dq_oe,
  input  logic [DATA_W-1:0]     sd_dq_in
);
  localparam int BR_W    = BANK_W + ROW_W;
  localparam int RD_LAT  = CAS_LAT + 2;
  localparam int CNT_MAX = (TRCD_NOPS > TRP_NOPS) ? TRCD_NOPS : TRP_NOPS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [ROW_W-1:0] A_ALLBANKS = ROW_W'(1024);

  typedef enum logic [1:0] {S_IDLE, S_AWAIT, S_COL, S_PWAIT} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               own_rd, last_rd;
  logic [BR_W-1:0]    open_br;
  logic [RD_LAT-1:0]  vpipe;
  logic [ROW_W-1:0]   col_a;

  wire              pick_rd   = rd_req & (~wr_req | ~last_rd);
  wire [ADDR_W-1:0] idle_addr = pick_rd ? rd_addr : wr_addr;
  wire              own_req   = own_rd ? rd_req : wr_req;
  wire [ADDR_W-1:0] own_addr  = own_rd ? rd_addr : wr_addr;
  wire              hit       = own_req && (own_addr[ADDR_W-1:COL_W] == open_br);
  wire              col_go    = (state == S_COL) && hit;

  assign wr_grant = col_go & ~own_rd;
  assign rd_grant = col_go & own_rd;
  assign rd_valid = vpipe[RD_LAT-1];

  always_comb begin
    col_a = '0;
    col_a[COL_W-1:0] = own_addr[COL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      own_rd    <= 1'b0;
      last_rd   <= 1'b1;
      open_br   <= '0;
      vpipe     <= '0;
      rd_data   <= '0;
      sd_cmd    <= CMD_NOP;
      sd_ba     <= '0;
      sd_a      <= '0;
      sd_dqm    <= '1;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
    end else begin
      sd_cmd   <= CMD_NOP;
      sd_ba    <= '0;
      sd_a     <= '0;
      sd_dqm   <= '1;
      sd_dq_oe <= 1'b0;
      vpipe    <= {vpipe[RD_LAT-2:0], rd_grant};
      rd_data  <= sd_dq_in;
      case (state)
        S_IDLE: if (wr_req | rd_req) begin
          sd_cmd  <= CMD_ACT;
          sd_ba   <= idle_addr[ADDR_W-1 -: BANK_W];
          sd_a    <= idle_addr[COL_W +: ROW_W];
          open_br <= idle_addr[ADDR_W-1:COL_W];
          own_rd  <= pick_rd;
          last_rd <= pick_rd;
          if (TRCD_NOPS == 0) state <= S_COL;
          else begin
            state <= S_AWAIT;
            cnt   <= CNT_W'(TRCD_NOPS - 1);
          end
        end
        S_AWAIT: if (cnt == '0) state <= S_COL; else cnt <= cnt - 1'b1;
        S_COL: if (hit) begin
          sd_cmd    <= own_rd ? CMD_RD : CMD_WR;
          sd_ba     <= open_br[BR_W-1 -: BANK_W];
          sd_a      <= col_a;
          sd_dqm    <= '0;
          sd_dq_oe  <= ~own_rd;
          sd_dq_out <= wr_data;
        end else begin
          sd_cmd <= CMD_PRE;
          sd_a   <= A_ALLBANKS;
          if (TRP_NOPS == 0) state <= S_IDLE;
          else begin
            state <= S_PWAIT;
            cnt   <= CNT_W'(TRP_NOPS - 1);
          end
        end
        S_PWAIT: if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  grant_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant | rd_grant) |=> (sd_cmd == CMD_RD || sd_cmd == CMD_WR));
  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && rd_grant));
  // R3
  dqm_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_dqm != '1) |-> (sd_cmd == CMD_RD || sd_cmd == CMD_WR));
  // R4
  oe_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (sd_cmd == CMD_WR));
  // R7
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_PRE) |-> sd_a[10]);
  // R2
  col_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> !sd_a[10]);

  if (TRCD_NOPS > 0) begin : g_act_gap
    // R5
    act_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_ACT) |=> (sd_cmd == CMD_NOP));
  end
  if (TRP_NOPS > 0) begin : g_pre_gap
    // R7
    pre_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |=> (sd_cmd == CMD_NOP));
  end
endmodule

// File: tb/tb_sdram_dualport_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_dualport_ctrl;
  localparam int CAS = 2, TRCD = 1, TRP = 2, LAT = CAS + 2, LOGN = 4096;
  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010;
  // {is_write, address(bank,row,col), write data}
  localparam logic [36:0] VEC [6] = '{
    {1'b1, 20'h00000, 16'h1234}, {1'b0, 20'h00000, 16'h0000},
    {1'b1, 20'hFFFFF, 16'hBEEF}, {1'b0, 20'hFFFFF, 16'h0000},
    {1'b0, 20'h7AB3C, 16'h0000}, {1'b1, 20'h8015A, 16'h0F0F}};

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, rd_req = 0;
  logic [19:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, sd_dq_in = '0;
  logic wr_grant, rd_grant, rd_valid, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [2:0] sd_cmd;
  logic [0:0] sd_ba;
  logic [10:0] sd_a;
  logic [1:0] sd_dqm;
  int cyc = 0, n_chk = 0, n_fail = 0;

  logic [2:0]  l_cmd [LOGN];
  logic        l_ba  [LOGN];
  logic [10:0] l_a   [LOGN];
  logic [1:0]  l_dqm [LOGN];
  logic [15:0] l_dqo [LOGN];
  logic        l_oe  [LOGN];
  logic        l_rv  [LOGN];
  logic [15:0] l_rd  [LOGN];
  logic [15:0] hist [CAS+1];
  logic [10:0] cur_row = '0;

  sdram_dualport_ctrl #(.CAS_LAT(CAS), .TRCD_NOPS(TRCD), .TRP_NOPS(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_grant(wr_grant), .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant),
    .rd_data(rd_data), .rd_valid(rd_valid), .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_a(sd_a),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] rdval(logic b, logic [10:0] r, logic [7:0] c);
    return {r[7:0] ^ 8'h5A, c} ^ {15'd0, b};
  endfunction

  always @(negedge clk) begin
    if (cyc < LOGN) begin
      l_cmd[cyc] = sd_cmd; l_ba[cyc] = sd_ba[0]; l_a[cyc] = sd_a; l_dqm[cyc] = sd_dqm;
      l_dqo[cyc] = sd_dq_out; l_oe[cyc] = sd_dq_oe; l_rv[cyc] = rd_valid; l_rd[cyc] = rd_data;
    end
    if (sd_cmd == ACT) cur_row = sd_a;
    for (int k = CAS; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = (sd_cmd == RD) ? rdval(sd_ba[0], cur_row, sd_a[7:0]) : 16'hDEAD;
    sd_dq_in = hist[CAS];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_grant(input bit wr, output int g);
    int n = 0;
    #1;
    while (!(wr ? wr_grant : rd_grant) && n < 60) begin @(posedge clk); #2; n++; end
    g = cyc;
    if (n >= 60) chk(0, "R6", "grant timeout", 0, 1);
  endtask

  task automatic access(input bit wr, input logic [19:0] addr, input logic [15:0] d, output int g);
    @(posedge clk); #1;
    if (wr) begin wr_req = 1; wr_addr = addr; wr_data = d; end
    else begin rd_req = 1; rd_addr = addr; end
    wait_grant(wr, g);
    @(posedge clk); #1; wr_req = 0; rd_req = 0;
    repeat (LAT + 4) @(posedge clk);
  endtask

  task automatic conflict(output int gw, output int gr);
    bit both = 0;
    gw = -1; gr = -1;
    @(posedge clk); #1;
    wr_req = 1; wr_addr = {1'b0, 11'h022, 8'h33}; wr_data = 16'hA5A5;
    rd_req = 1; rd_addr = {1'b1, 11'h044, 8'h55};
    for (int n = 0; n < 60; n++) begin
      #1;
      if (wr_grant && rd_grant) both = 1;
      if (wr_grant && gw < 0) gw = cyc;
      if (rd_grant && gr < 0) gr = cyc;
      if (gw >= 0 && gr >= 0) break;
      @(posedge clk); #1;
      if (gw >= 0) wr_req = 0;
      if (gr >= 0) rd_req = 0;
    end
    @(posedge clk); #1; wr_req = 0; rd_req = 0;
    chk(!both, "R9", "both grants high", 32'(both), 0);
    repeat (LAT + 4) @(posedge clk);
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g, g2, gw, gr, acts;
    for (int k = 0; k <= CAS; k++) hist[k] = 16'hDEAD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(sd_cmd == NOP && sd_dqm == 2'b11 && !sd_dq_oe, "R1", "reset pins",
        {sd_cmd, sd_dqm, sd_dq_oe}, {NOP, 2'b11, 1'b0});
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!wr_grant && !rd_grant && !rd_valid && sd_cmd == NOP, "R1", "after reset",
        {wr_grant, rd_grant, rd_valid, sd_cmd}, {3'b000, NOP});

    for (int i = 0; i < 6; i++) begin
      logic w; logic [19:0] ad; logic [15:0] d;
      {w, ad, d} = VEC[i];
      access(w, ad, d, g);
      chk(l_cmd[g-1] == ACT && l_ba[g-1] == ad[19] && l_a[g-1] == ad[18:8], "R2", "activate",
          {l_cmd[g-1], l_ba[g-1], l_a[g-1]}, {ACT, ad[19], ad[18:8]});
      chk(l_cmd[g] == NOP, "R5", "trcd gap", l_cmd[g], NOP);
      chk(l_cmd[g+1] == (w ? WR : RD) && l_ba[g+1] == ad[19] && l_a[g+1] == {3'b000, ad[7:0]},
          "R2", "column cmd", {l_cmd[g+1], l_ba[g+1], l_a[g+1]}, {(w ? WR : RD), ad[19], 3'b000, ad[7:0]});
      chk(l_dqm[g+1] == 2'b00 && l_dqm[g] == 2'b11 && l_dqm[g+2] == 2'b11, "R3", "dqm",
          {l_dqm[g], l_dqm[g+1], l_dqm[g+2]}, 6'b110011);
      if (w) begin
        chk(l_oe[g+1] && l_dqo[g+1] == d && !l_oe[g+2], "R4", "write data",
            {l_oe[g+1], l_dqo[g+1], l_oe[g+2]}, {1'b1, d, 1'b0});
        chk(!l_rv[g+LAT], "R8", "no valid on write", l_rv[g+LAT], 0);
      end else begin
        chk(l_rv[g+LAT] && l_rd[g+LAT] == rdval(ad[19], ad[18:8], ad[7:0]), "R8", "read data",
            {l_rv[g+LAT], l_rd[g+LAT]}, {1'b1, rdval(ad[19], ad[18:8], ad[7:0])});
        chk(!l_rv[g+LAT-1] && !l_rv[g+LAT+1], "R8", "valid width",
            {l_rv[g+LAT-1], l_rv[g+LAT+1]}, 0);
      end
      chk(l_cmd[g+2] == PRE && l_a[g+2][10] && l_cmd[g+3] == NOP && l_cmd[g+4] == NOP, "R7",
          "precharge", {l_cmd[g+2], l_a[g+2][10], l_cmd[g+3], l_cmd[g+4]}, {PRE, 1'b1, NOP, NOP});
    end

    // R6 same-row burst of four reads
    @(posedge clk); #1; rd_req = 1; rd_addr = {1'b1, 11'h155, 8'h10};
    wait_grant(0, g);
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); #1; rd_addr = {1'b1, 11'h155, 8'(8'h10 + k)};
      #1 chk(rd_grant, "R6", "burst grant", rd_grant, 1);
    end
    @(posedge clk); #1; rd_req = 0;
    repeat (LAT + 6) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(l_cmd[g+1+k] == RD && l_a[g+1+k] == 11'(8'h10 + k), "R6", "burst column",
          {l_cmd[g+1+k], l_a[g+1+k]}, {RD, 11'(8'h10 + k)});
      chk(l_rv[g+LAT+k] && l_rd[g+LAT+k] == rdval(1'b1, 11'h155, 8'(8'h10 + k)), "R8",
          "burst data", {l_rv[g+LAT+k], l_rd[g+LAT+k]}, {1'b1, rdval(1'b1, 11'h155, 8'(8'h10 + k))});
    end
    acts = 0;
    for (int c = g - 1; c <= g + 6; c++) if (l_cmd[c] == ACT) acts++;
    chk(acts == 1, "R6", "single activate", acts, 1);
    chk(l_cmd[g+5] == PRE, "R7", "burst close", l_cmd[g+5], PRE);

    // R7 bank change while request held
    @(posedge clk); #1; rd_req = 1; rd_addr = {1'b0, 11'h010, 8'h01};
    wait_grant(0, g);
    @(posedge clk); #1; rd_addr = {1'b1, 11'h010, 8'h02};
    #1 chk(!rd_grant, "R9", "no grant after bank move", rd_grant, 0);
    wait_grant(0, g2);
    @(posedge clk); #1; rd_req = 0;
    repeat (LAT + 4) @(posedge clk);
    chk(g2 == g + TRP + TRCD + 3, "R7", "regrant delay", g2 - g, TRP + TRCD + 3);
    chk(l_cmd[g+2] == PRE && l_cmd[g+3] == NOP && l_cmd[g+4] == NOP && l_cmd[g+5] == ACT &&
        l_ba[g+5] == 1'b1, "R7", "reopen sequence",
        {l_cmd[g+2], l_cmd[g+3], l_cmd[g+4], l_cmd[g+5]}, {PRE, NOP, NOP, ACT});
    chk(l_cmd[g2+1] == RD && l_ba[g2+1] == 1'b1, "R2", "new bank read",
        {l_cmd[g2+1], l_ba[g2+1]}, {RD, 1'b1});

    // R10 last owner was the reader: writer wins
    conflict(gw, gr);
    chk(gw >= 0 && gr == gw + TRP + TRCD + 3, "R10", "writer first", gr - gw, TRP + TRCD + 3);
    // R10 after a lone write: reader wins
    access(1, {1'b0, 11'h300, 8'h07}, 16'h7777, g);
    conflict(gw, gr);
    chk(gr >= 0 && gw == gr + TRP + TRCD + 3, "R10", "reader first", gw - gr, TRP + TRCD + 3);
    chk(l_rv[gr+LAT] && l_rd[gr+LAT] == rdval(1'b1, 11'h044, 8'h55), "R8", "conflict read data",
        l_rd[gr+LAT], rdval(1'b1, 11'h044, 8'h55));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule